// File: doc/BRIEF.md
# Timer Prescaler Reset and Start-Alignment Controller

This block owns the clock prescalers for three timers and the small control register software uses to restart them. Two timers share one prescaler clocked by the system clock. The third timer has its own prescaler, which runs either from the system clock or, when `async_mode` is high, from a separate clock `aclk`. Each prescaler is a free-running counter. It gives the timers single-cycle tick enables at four fixed division ratios, and it halts while its reset is held.

Software restarts a prescaler by writing a one to that prescaler's reset bit. The bit normally drops by itself. When the bit belongs to the `aclk` domain, it stays set until the reset has crossed into that domain and an acknowledge has come back. A hold bit freezes both reset bits in their written state. Software can then load the timers with matching values while nothing advances. Clearing the hold bit releases both prescalers on the same edge, so the timers start in step.

Top module: `tmr_presync_ctrl`

## Requirements
- R1: After reset, `rd_data` reads 0x00, both halt outputs are low and no tick is asserted until a prescaler has counted from zero.
- R2: The register reads back as {hold bit at bit 7, zeros at bits 6..2, slow-timer reset at bit 1, shared reset at bit 0}. Writing ones to bits 6..2 has no effect and they read zero.
- R3: Writing 1 to bit 0 while bit 7 is 0 raises `sync_halt` for exactly one cycle, and bit 0 reads back zero on the next cycle. The shared prescaler restarts from zero, so its first divide-by-8 tick comes 8 cycles after the halt cycle.
- R4: With `async_mode` low, bit 1 behaves like bit 0 for the slow-timer prescaler. It drives `async_halt` for one cycle and clears itself on the next cycle.
- R5: While bit 7 is 1 and no write occurs, bits 1 and 0 keep their value. Their halt outputs stay high and the prescalers stay held.
- R6: A write that clears bit 7 and both reset bits releases both prescalers on the same edge. After that both prescalers give their divide-by-8 ticks in the same cycles.
- R7: A write that sets a reset bit and clears bit 7 at once holds that reset for one cycle only.
- R8: Each prescaler gives one-cycle ticks at divide-by-8, 64, 256 and 1024, counted from its last release (tick index 0..3 in that order).
- R9: No tick of a prescaler is asserted while its halt output is high.
- R10: With `async_mode` high, bit 1 stays one after it is written until the `aclk`-domain reset has been acknowledged. It then clears with no further write. Meanwhile `async_halt` (an `aclk`-domain signal in this mode) rises and then falls.
- R11: With `async_mode` high and bit 7 set, bit 1 and `async_halt` stay high indefinitely. Clearing the register releases them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronised on release in each domain |
| aclk | input | 1 | Separate clock for the slow timer's prescaler |
| async_mode | input | 1 | 1: slow-timer prescaler runs on `aclk`; change only while idle |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value |
| sync_tick | output | 4 | Shared prescaler tick enables (/8, /64, /256, /1024) |
| async_tick | output | 4 | Slow-timer prescaler tick enables (domain follows `async_mode`) |
| sync_halt | output | 1 | Shared prescaler held in reset |
| async_halt | output | 1 | Slow-timer prescaler held in reset |

## Verification
The assertions check on every cycle that no tick coincides with its halt and that each tick lasts a single cycle. They also check that a reset bit clears on the cycle after it is set unless the hold bit is set, that the hold bit freezes the reset bits, and that a pending `aclk` reset bit cannot clear before its acknowledge. Only the bench scenarios can show the exact tick phase after a release, the simultaneous restart of both prescalers when the hold is lifted, the one-cycle reset when a write drops the hold and sets a reset bit together, and the full round trip of the cross-domain request until the pending bit clears.

// File: rtl/tps_pkg.sv
package tps_pkg;
  localparam int unsigned REG_W      = 8;
  localparam int unsigned BIT_SHARED = 0;
  localparam int unsigned BIT_SLOW   = 1;
  localparam int unsigned BIT_HOLD   = 7;

  // Low counter bits that must all be one for a tick of the given tap.
  function automatic int unsigned tap_width(input int unsigned idx,
                                            input int unsigned cnt_w);
    case (idx)
      0:       return 3;
      1:       return 6;
      2:       return 8;
      default: return cnt_w;
    endcase
  endfunction
endpackage

// File: rtl/tps_sync2.sv
module tps_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/tps_prescaler.sv
module tps_prescaler #(
  parameter int unsigned CNT_W  = 10,
  parameter int unsigned N_TAPS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  output logic [N_TAPS-1:0] tick
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = hold ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
    localparam int unsigned TW = tps_pkg::tap_width(i, CNT_W);
    assign tick[i] = !hold && (&cnt_q[TW-1:0]);

    // R8: every tick is a single-cycle pulse
    p_tick_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tick[i] |=> !tick[i]);
  end
endmodule

// File: rtl/tps_ctrl_reg.sv
module tps_ctrl_reg
  import tps_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             async_mode,
  input  logic             ack_sync,
  output logic             hold_o,
  output logic             shared_rst_o,
  output logic             slow_rst_o
);
  logic hold_q, hold_d;
  logic shr_q, shr_d;
  logic slw_q, slw_d;
  logic wait_q, wait_d;
  logic ack_ok;
  logic upd_en;

  // A stale acknowledge from the previous request must drop before a new one counts.
  assign ack_ok = ack_sync && !wait_q;
  assign upd_en = wr_en || !hold_q;

  always_comb begin
    hold_d = hold_q;
    shr_d  = shr_q;
    slw_d  = slw_q;
    if (wr_en) begin
      hold_d = wr_data[BIT_HOLD];
      shr_d  = wr_data[BIT_SHARED];
      slw_d  = wr_data[BIT_SLOW];
    end else if (!hold_q) begin
      shr_d = 1'b0;
      if (!async_mode || ack_ok) slw_d = 1'b0;
    end
    wait_d = async_mode && ((slw_q && !slw_d) || (wait_q && ack_sync));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      shr_q  <= 1'b0;
      slw_q  <= 1'b0;
    end else if (upd_en) begin
      hold_q <= hold_d;
      shr_q  <= shr_d;
      slw_q  <= slw_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_q <= 1'b0;
    else        wait_q <= wait_d;
  end

  assign hold_o       = hold_q;
  assign shared_rst_o = shr_q;
  assign slow_rst_o   = slw_q;

  // R3: shared reset bit drops on the next cycle when not held
  p_self_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (shr_q && !hold_q && !wr_en) |=> !shr_q);

  // R5: the hold bit freezes both reset bits
  p_hold_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !wr_en) |=> (hold_q && $stable(shr_q) && $stable(slw_q)));

  // R10: a pending slow-domain reset never clears before its acknowledge
  p_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (async_mode && slw_q && !ack_sync && !wr_en) |=> slw_q);
endmodule

// File: rtl/tmr_presync_ctrl.sv
module tmr_presync_ctrl
  import tps_pkg::*;
#(
  parameter int unsigned CNT_W  = 10,
  parameter int unsigned N_TAPS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              aclk,
  input  logic              async_mode,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  output logic [N_TAPS-1:0] sync_tick,
  output logic [N_TAPS-1:0] async_tick,
  output logic              sync_halt,
  output logic              async_halt
);
  logic rst_core_n, rst_slow_n;
  logic hold, shr_rst, slw_rst;
  logic req_x, req_a, ack_c;
  logic slow_c_hold;
  logic [N_TAPS-1:0] tick_slow_c, tick_slow_a;

  tps_sync2 #(.RST_VAL(1'b0)) u_rst_core (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_core_n));
  tps_sync2 #(.RST_VAL(1'b0)) u_rst_slow (
    .clk(aclk), .rst_n(rst_n), .d(1'b1), .q(rst_slow_n));

  tps_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_core_n), .wr_en(wr_en), .wr_data(wr_data),
    .async_mode(async_mode), .ack_sync(ack_c),
    .hold_o(hold), .shared_rst_o(shr_rst), .slow_rst_o(slw_rst));

  // Request into the aclk domain, acknowledge echoed back.
  assign req_x = async_mode && slw_rst;

  tps_sync2 #(.RST_VAL(1'b0)) u_req_sync (
    .clk(aclk), .rst_n(rst_slow_n), .d(req_x), .q(req_a));
  tps_sync2 #(.RST_VAL(1'b0)) u_ack_sync (
    .clk(clk), .rst_n(rst_core_n), .d(req_a), .q(ack_c));

  tps_prescaler #(.CNT_W(CNT_W), .N_TAPS(N_TAPS)) u_pre_shared (
    .clk(clk), .rst_n(rst_core_n), .hold(shr_rst), .tick(sync_tick));

  assign slow_c_hold = slw_rst || async_mode;

  tps_prescaler #(.CNT_W(CNT_W), .N_TAPS(N_TAPS)) u_pre_slow_c (
    .clk(clk), .rst_n(rst_core_n), .hold(slow_c_hold), .tick(tick_slow_c));

  tps_prescaler #(.CNT_W(CNT_W), .N_TAPS(N_TAPS)) u_pre_slow_a (
    .clk(aclk), .rst_n(rst_slow_n), .hold(req_a), .tick(tick_slow_a));

  always_comb begin
    rd_data             = '0;
    rd_data[BIT_HOLD]   = hold;
    rd_data[BIT_SLOW]   = slw_rst;
    rd_data[BIT_SHARED] = shr_rst;
  end

  assign sync_halt  = shr_rst;
  assign async_halt = async_mode ? req_a : slw_rst;
  assign async_tick = async_mode ? tick_slow_a : tick_slow_c;

  // R9: no tick during halt, per clock domain
  p_no_tick_sync_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    sync_halt |-> (sync_tick == '0));
  p_no_tick_slowc_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!async_mode && async_halt) |-> (async_tick == '0));
  p_no_tick_slowa_r9: assert property (@(posedge aclk) disable iff (!rst_slow_n)
    (async_mode && async_halt) |-> (async_tick == '0));
endmodule

// File: tb/tmr_presync_ctrl_tb.sv
module tmr_presync_ctrl_tb;
  logic       clk = 1'b0;
  logic       aclk = 1'b0;
  logic       rst_n = 1'b0;
  logic       async_mode = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [3:0] sync_tick, async_tick;
  logic       sync_halt, async_halt;

  int total = 0;
  int bad = 0;
  string cur_req = "R1";
  bit mdl_on = 1'b0;

  always #5 clk = ~clk;
  always #17 aclk = ~aclk;

  tmr_presync_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .aclk(aclk), .async_mode(async_mode),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .sync_tick(sync_tick), .async_tick(async_tick),
    .sync_halt(sync_halt), .async_halt(async_halt));

  // Behavioural reference model of the clk-domain outputs.
  bit r1 = 0, r2 = 0;
  bit m_t = 0, m_s = 0, m_a = 0;
  int m_cs = 0, m_ca = 0;
  int divs[4] = '{8, 64, 256, 1024};

  always @(posedge clk) begin
    bit s_old, a_old;
    if (!r2) begin
      m_t = 0; m_s = 0; m_a = 0; m_cs = 0; m_ca = 0;
    end else begin
      s_old = m_s; a_old = m_a;
      m_cs = s_old ? 0 : (m_cs + 1) % 1024;
      m_ca = (a_old || async_mode) ? 0 : (m_ca + 1) % 1024;
      if (wr_en) begin
        m_t = wr_data[7]; m_s = wr_data[0]; m_a = wr_data[1];
      end else if (!m_t) begin
        m_s = 0;
        if (!async_mode) m_a = 0;
      end
      if (async_mode) m_a = 0;
    end
    r2 = r1;
    r1 = rst_n;
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [7:0] erd, mask;
    logic [3:0] est, eat;
    if (mdl_on) begin
      mask = async_mode ? 8'hFD : 8'hFF;
      erd = {m_t, 5'b0, m_a, m_s};
      for (int i = 0; i < 4; i++) begin
        est[i] = !m_s && ((m_cs % divs[i]) == divs[i] - 1);
        eat[i] = !m_a && ((m_ca % divs[i]) == divs[i] - 1);
      end
      chk("rd_data", rd_data & mask, erd & mask);
      chk("sync_halt", sync_halt, m_s);
      chk("sync_tick(R8)", sync_tick, est);
      if (sync_halt) chk("sync tick in halt R9", sync_tick, 4'h0);
      if (!async_mode) begin
        chk("async_halt", async_halt, m_a);
        chk("async_tick(R8)", async_tick, eat);
      end
    end
  end

  // aclk-domain observation in async mode.
  bit seen_ahalt = 0;
  int a_ticks = 0;
  always @(posedge aclk) begin
    #1;
    if (mdl_on && async_mode) begin
      if (async_halt) begin
        seen_ahalt = 1;
        total++;
        if (async_tick !== 4'h0) begin
          bad++;
          $display("FAIL R9 async tick during halt act=%h exp=0", async_tick);
        end
      end
      if (async_tick[0]) a_ticks++;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    int waitc;
    idle(3); #1;
    rst_n = 1'b1;
    mdl_on = 1'b1;
    idle(4); @(negedge clk);
    cur_req = "R1";
    chk("reset rd_data R1", rd_data, 8'h00);
    chk("reset halts R1", {sync_halt, async_halt}, 2'b00);

    cur_req = "R8"; idle(1100);
    cur_req = "R3"; wr(8'h01); idle(40);
    cur_req = "R4"; wr(8'h02); idle(40);
    cur_req = "R2"; wr(8'hFF); idle(30);
    @(negedge clk);
    chk("R2 bits 6..2 zero", rd_data[6:2], 5'h00);
    cur_req = "R6"; wr(8'h00); idle(300);
    cur_req = "R5"; wr(8'h83); idle(60);
    @(negedge clk);
    chk("R5 held halts", {sync_halt, async_halt}, 2'b11);
    cur_req = "R6"; wr(8'h00); idle(80);
    cur_req = "R7"; wr(8'h80); idle(10); wr(8'h03); idle(80);
    cur_req = "R7"; wr(8'h81); idle(10); wr(8'h02); idle(80);

    // Slow-timer prescaler on aclk.
    @(posedge clk); #1; async_mode = 1'b1;
    idle(40);
    cur_req = "R10";
    seen_ahalt = 0;
    wr(8'h02);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10 bit1 pending", rd_data[1], 1'b1);
    end
    waitc = 0;
    while (rd_data[1] && waitc < 400) begin @(negedge clk); waitc++; end
    chk("R10 bit1 cleared by ack", rd_data[1], 1'b0);
    chk("R10 async_halt seen", seen_ahalt, 1'b1);
    idle(60);
    a_ticks = 0;
    idle(300);
    chk("R10 aclk ticks resume", a_ticks > 0, 1'b1);

    cur_req = "R11";
    wr(8'h82); idle(150);
    @(negedge clk);
    chk("R11 bit1 held", rd_data[1], 1'b1);
    chk("R11 async_halt held", async_halt, 1'b1);
    wr(8'h00);
    @(negedge clk);
    chk("R11 bit1 released", rd_data[1], 1'b0);
    idle(30);
    @(negedge clk);
    chk("R11 async_halt released", async_halt, 1'b0);
    idle(30);
    @(posedge clk); #1; async_mode = 1'b0;
    cur_req = "R4"; idle(40); wr(8'h02); idle(1100);

    summary();
    $finish;
  end
endmodule